// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives a serial flash device over a single-select SPI link in mode 3: the clock idles high and both sides sample on the rising edge. A host on a simple register bus loads an address word and a data word, then writes a command word. That command write starts one transaction. The transaction shifts out an opcode, an optional address, optional zero-valued dummy bytes, and up to four data bytes. The data bytes are either taken from the data word or captured from the device into it.

A flash operation longer than four data bytes is built from several commands. The first command carries the opcode and address and sets the keep-selected bit, so the select line stays low after it finishes. Each continuation command issued while the select is held shifts only its data bytes. A final command with no data and keep-selected clear just lets the select line go high. Serial-clock timing is set in system-clock cycles: a bit-slot length, a fall position and a rise position within the slot. A status word reports a pending flag while a command runs and a sticky error flag for commands that were refused.

Top module: `sflash_seq`

## Requirements
- R1: A write to the command word (bus address 2) starts a transaction. From the next cycle, status bit 22 (pending) reads 1 for N*T+1 cycles, where N is the number of bits shifted and T is the slot length. It then reads 0.
- R2: When the select is not already held, the transaction opens with the 8-bit opcode from command bits 7:0. Every byte goes out most significant bit first on MOSI, one bit per slot.
- R3: Command bits 22:20 give an address length of 0 to 3 bytes. These bytes are the low bytes of the address word (bus address 0), sent most significant byte first.
- R4: Command bits 19:16 give 0 to 15 dummy bytes, sent as zeros after the address.
- R5: Command bits 11:9 give 0 to 4 data bytes. When bit 8 is 1, the data bytes are sent from the data word (bus address 1), least significant byte first.
- R6: When bit 8 is 0 and the data length is not zero, MISO is captured during each data slot at the cycle the serial clock rises. The captured bytes are packed into the data word least significant byte first. The data word is replaced when the command completes, and unused upper bytes read 0.
- R7: When command bit 15 (keep-selected) is set, the active-low select stays low after completion. A command issued while the select is held skips the opcode. A command with zero data length and bit 15 clear, issued while held, only releases the select.
- R8: A command write while pending is ignored and sets the error flag, status bit 29.
- R9: A command write is refused and sets the error flag in any of these cases: the address length is above 3, the data length is above 4, or the select is held and the address length or dummy count is non-zero.
- R10: Writing the status word (bus address 3) with bit 29 set clears the error flag. Writing it with bit 29 clear leaves the flag unchanged.
- R11: Timing word (bus address 4): bits 3:0 give the slot length T (values below 2 act as 2), bits 15:12 the fall position F, and bits 11:8 the rise position R. Within each slot, SCK is low exactly for slot counts F to R-1. SCK is high whenever no bit is shifting, and MOSI is 0 outside bit slots.
- R12: After reset, the select is high, SCK is high, the status reads 0, and the timing word reads 0x0204.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |
| cs_no | output | 1 | Active-low device select |

## Verification
The hardest conditions to reach from the ports are those that depend on the select being held: the opcode-free continuation, the release-only command, and the refusal of an address-bearing command while held. Each is reached only through a preceding keep-selected command. The stimulus therefore chains commands into multi-step flash operations and checks the select line and status between the steps. A behavioural model predicts SCK, MOSI and the select on every cycle. It also plays the device side, presenting read bits on MISO slot by slot, so that refusals during a pending command and odd timing values (a slot length below 2, a shifted fall edge) are seen bit-exact.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam logic [2:0] A_ADDR = 3'd0;
  localparam logic [2:0] A_DATA = 3'd1;
  localparam logic [2:0] A_CMD  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_TIME = 3'd4;

  localparam int DIR_BIT  = 8;
  localparam int DLEN_LSB = 9;
  localparam int KEEP_BIT = 15;
  localparam int DUM_LSB  = 16;
  localparam int ALEN_LSB = 20;
  localparam int PEND_BIT = 22;
  localparam int ERR_BIT  = 29;

  localparam logic [15:0] TIME_RST = 16'h0204;

  typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_END} phase_e;

  typedef struct packed {
    logic [7:0] opc;
    logic       wr;
    logic [2:0] dlen;
    logic       keep;
    logic [3:0] dum;
    logic [2:0] alen;
  } cmd_t;
endpackage

// File: rtl/sfs_regs.sv
module sfs_regs
  import sfs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        busy_i,
  input  logic        held_i,
  input  logic        rd_load_i,
  input  logic [31:0] rd_word_i,
  output logic        launch_o,
  output cmd_t        cmd_o,
  output logic [23:0] fadr_o,
  output logic [31:0] data_o,
  output logic [15:0] tim_o
);
  logic [23:0] adr_q;
  logic [31:0] data_q, cmd_q;
  logic [15:0] tim_q;
  logic        err_q;
  cmd_t        c_in;
  logic        cmd_wr, bad, err_set, err_clr;

  always_comb begin
    c_in.opc  = wdata_i[7:0];
    c_in.wr   = wdata_i[DIR_BIT];
    c_in.dlen = wdata_i[DLEN_LSB +: 3];
    c_in.keep = wdata_i[KEEP_BIT];
    c_in.dum  = wdata_i[DUM_LSB +: 4];
    c_in.alen = wdata_i[ALEN_LSB +: 3];
  end

  assign cmd_wr  = we_i && (addr_i == A_CMD);
  assign bad     = busy_i || (c_in.alen > 3'd3) || (c_in.dlen > 3'd4) ||
                   (held_i && ((c_in.alen != 3'd0) || (c_in.dum != 4'd0)));
  assign launch_o = cmd_wr && !bad;
  assign err_set  = cmd_wr && bad;
  assign err_clr  = we_i && (addr_i == A_STAT) && wdata_i[ERR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q  <= '0;
      data_q <= '0;
      cmd_q  <= '0;
      tim_q  <= TIME_RST;
      err_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == A_ADDR) adr_q <= wdata_i[23:0];
      if (rd_load_i) data_q <= rd_word_i;
      else if (we_i && addr_i == A_DATA) data_q <= wdata_i;
      if (launch_o) cmd_q <= wdata_i;
      if (we_i && addr_i == A_TIME) tim_q <= wdata_i[15:0];
      if (err_set) err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_ADDR: rdata_o = {8'h00, adr_q};
      A_DATA: rdata_o = data_q;
      A_CMD:  rdata_o = cmd_q;
      A_STAT: begin
        rdata_o[ERR_BIT]  = err_q;
        rdata_o[PEND_BIT] = busy_i;
      end
      A_TIME: rdata_o = {16'h0000, tim_q};
      default: rdata_o = '0;
    endcase
  end

  assign cmd_o  = c_in;
  assign fadr_o = adr_q;
  assign data_o = data_q;
  assign tim_o  = tim_q;

  assert_busy_cmd_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i) |=> err_q) else $error("command while pending did not flag");
  assert_err_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr |=> !err_q) else $error("error flag not cleared");
endmodule

// File: rtl/sfs_clkgen.sv
module sfs_clkgen #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  output logic             slot_end_o,
  output logic             sample_o,
  output logic             sck_o
);
  localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, t_last;

  assign t_last = (per_i < CNT_W'(2)) ? MIN_LAST : per_i - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || slot_end_o)  cnt_q <= '0;
    else                            cnt_q <= cnt_q + CNT_W'(1);
  end

  assign slot_end_o = run_i && (cnt_q == t_last);
  assign sample_o   = run_i && (cnt_q == rise_i);
  assign sck_o      = !(run_i && (cnt_q >= fall_i) && (cnt_q < rise_i));

  assert_slot_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && slot_end_o) |=> (cnt_q == '0)) else $error("slot counter did not wrap");
endmodule

// File: rtl/sfs_seq.sv
module sfs_seq
  import sfs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        launch_i,
  input  cmd_t        c_i,
  input  logic [23:0] fadr_i,
  input  logic [31:0] txd_i,
  input  logic        slot_end_i,
  input  logic        sample_i,
  input  logic        miso_i,
  output logic        busy_o,
  output logic        run_o,
  output logic        held_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  output logic        rd_load_o,
  output logic [31:0] rd_word_o
);
  logic        busy_q, cs_q;
  phase_e      phase_q;
  logic [3:0]  byte_q, len_m1, ab4;
  logic [2:0]  bit_q;
  cmd_t        c_q;
  logic [23:0] adr_q, adr_sh;
  logic [31:0] txd_q, rx_q, dat_sh;
  logic [6:0]  ash;
  logic [5:0]  dsh;

  function automatic phase_e nxt(phase_e p, cmd_t c);
    phase_e r;
    r = PH_END;
    case (p)
      PH_OPC: r = (c.alen != 3'd0) ? PH_ADR : (c.dum != 4'd0) ? PH_DUM :
                  (c.dlen != 3'd0) ? PH_DAT : PH_END;
      PH_ADR: r = (c.dum != 4'd0) ? PH_DUM : (c.dlen != 3'd0) ? PH_DAT : PH_END;
      PH_DUM: r = (c.dlen != 3'd0) ? PH_DAT : PH_END;
      default: r = PH_END;
    endcase
    return r;
  endfunction

  always_comb begin
    case (phase_q)
      PH_ADR:  len_m1 = 4'(c_q.alen) - 4'd1;
      PH_DUM:  len_m1 = c_q.dum - 4'd1;
      PH_DAT:  len_m1 = 4'(c_q.dlen) - 4'd1;
      default: len_m1 = 4'd0;
    endcase
  end

  // address bytes leave high byte first, data bytes low byte first
  assign ab4    = 4'(c_q.alen) - 4'd1 - byte_q;
  assign ash    = 7'(ab4) << 3;
  assign adr_sh = adr_q >> ash;
  assign dsh    = 6'(byte_q) << 3;
  assign dat_sh = txd_q >> dsh;

  always_comb begin
    mosi_o = 1'b0;
    if (busy_q) begin
      case (phase_q)
        PH_OPC:  mosi_o = c_q.opc[~bit_q];
        PH_ADR:  mosi_o = adr_sh[~bit_q];
        PH_DAT:  mosi_o = c_q.wr & dat_sh[~bit_q];
        default: mosi_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cs_q    <= 1'b0;
      phase_q <= PH_END;
      byte_q  <= '0;
      bit_q   <= '0;
      c_q     <= '0;
      adr_q   <= '0;
      txd_q   <= '0;
      rx_q    <= '0;
    end else if (launch_i) begin
      busy_q  <= 1'b1;
      cs_q    <= 1'b1;
      phase_q <= cs_q ? nxt(PH_OPC, c_i) : PH_OPC;
      byte_q  <= '0;
      bit_q   <= '0;
      c_q     <= c_i;
      adr_q   <= fadr_i;
      txd_q   <= txd_i;
      rx_q    <= '0;
    end else if (busy_q) begin
      if (phase_q == PH_END) begin
        busy_q <= 1'b0;
        cs_q   <= c_q.keep;
      end else begin
        if (sample_i && phase_q == PH_DAT && !c_q.wr)
          rx_q[{byte_q[1:0], ~bit_q}] <= miso_i;
        if (slot_end_i) begin
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (byte_q == len_m1) begin
              byte_q  <= '0;
              phase_q <= nxt(phase_q, c_q);
            end else begin
              byte_q <= byte_q + 4'd1;
            end
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign run_o     = busy_q && (phase_q != PH_END);
  assign held_o    = cs_q;
  assign cs_n_o    = !(cs_q || busy_q);
  assign rd_load_o = busy_q && (phase_q == PH_END) && !c_q.wr && (c_q.dlen != 3'd0);
  assign rd_word_o = rx_q;

  assert_launch_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q) else $error("launch while busy");
  assert_len_limit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> (c_i.alen <= 3'd3 && c_i.dlen <= 3'd4)) else $error("oversize launch");
  assert_cont_no_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && cs_q) |-> (c_i.alen == 3'd0 && c_i.dum == 4'd0)) else $error("address on continuation");
  assert_keep_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && phase_q == PH_END && c_q.keep) |=> cs_q) else $error("select dropped");
  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && phase_q == PH_END && !c_q.keep) |=> (!cs_q && !busy_q)) else $error("select not released");
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sfs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no
);
  localparam int RISE_LSB = 8;
  localparam int FALL_LSB = 12;

  logic        launch_w, busy_w, run_w, held_w, rd_load_w, slot_end_w, sample_w;
  cmd_t        cmd_w;
  logic [23:0] fadr_w;
  logic [31:0] data_w, rd_word_w;
  logic [15:0] tim_w;

  sfs_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_w), .held_i(held_w), .rd_load_i(rd_load_w), .rd_word_i(rd_word_w),
    .launch_o(launch_w), .cmd_o(cmd_w), .fadr_o(fadr_w), .data_o(data_w), .tim_o(tim_w)
  );

  sfs_clkgen #(.CNT_W(CNT_W)) u_clk (
    .clk_i, .rst_ni, .run_i(run_w),
    .per_i(tim_w[CNT_W-1:0]), .rise_i(tim_w[RISE_LSB +: CNT_W]), .fall_i(tim_w[FALL_LSB +: CNT_W]),
    .slot_end_o(slot_end_w), .sample_o(sample_w), .sck_o(sck_o)
  );

  sfs_seq u_seq (
    .clk_i, .rst_ni, .launch_i(launch_w), .c_i(cmd_w), .fadr_i(fadr_w), .txd_i(data_w),
    .slot_end_i(slot_end_w), .sample_i(sample_w), .miso_i(miso_i),
    .busy_o(busy_w), .run_o(run_w), .held_o(held_w), .cs_n_o(cs_no), .mosi_o(mosi_o),
    .rd_load_o(rd_load_w), .rd_word_o(rd_word_w)
  );

  assert_idle_sck_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w |-> sck_o) else $error("sck not idle high");
  assert_run_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> !cs_no) else $error("shifting without select");
endmodule

// File: tb/sflash_seq_test.sv
module sflash_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        we = 1'b0, miso = 1'b0;
  logic [2:0]  ra = '0;
  logic [31:0] wd = '0;
  wire  [31:0] rd;
  wire         sck, mosi, cs_n;

  sflash_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;

  // reference model state
  bit          m_busy, m_held, m_err, m_keep, m_wr, ob;
  int          m_c, m_n, m_dlen, t, s, k, alen, dum, dlen;
  logic [31:0] m_data, rx_word;
  logic [23:0] m_addr;
  logic [15:0] m_tim;
  logic [7:0]  byt;
  bit          m_bits[$], m_rd[$], rx_bits[$];
  int          rx_i;
  bit          e_sck, e_mosi, e_cs;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int teff();
    return (m_tim[3:0] < 4'd2) ? 2 : int'(m_tim[3:0]);
  endfunction

  function automatic logic [31:0] stat_exp();
    return (32'(m_err) << 29) | (32'(m_busy) << 22);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_held = 0; m_err = 0; m_keep = 0; m_wr = 0;
      m_c = 0; m_n = 0; m_dlen = 0; m_data = '0; m_addr = '0; m_tim = 16'h0204;
    end else begin
      ob = m_busy;
      if (m_busy) begin
        if (m_c == m_n * teff()) begin
          m_busy = 0; m_held = m_keep;
          if (!m_wr && m_dlen > 0) m_data = rx_word;
        end else m_c++;
      end
      if (we) begin
        case (ra)
          3'd0: m_addr = wd[23:0];
          3'd1: m_data = wd;
          3'd3: if (wd[29]) m_err = 0;
          3'd4: m_tim = wd[15:0];
          3'd2: begin
            alen = int'(wd[22:20]); dum = int'(wd[19:16]); dlen = int'(wd[11:9]);
            if (ob || alen > 3 || dlen > 4 || (m_held && (alen != 0 || dum != 0))) m_err = 1;
            else begin
              m_bits.delete(); m_rd.delete();
              if (!m_held)
                for (int b = 7; b >= 0; b--) begin m_bits.push_back(wd[b]); m_rd.push_back(0); end
              for (int a = alen - 1; a >= 0; a--) begin
                byt = m_addr[8*a +: 8];
                for (int b = 7; b >= 0; b--) begin m_bits.push_back(byt[b]); m_rd.push_back(0); end
              end
              for (int d = 0; d < dum * 8; d++) begin m_bits.push_back(0); m_rd.push_back(0); end
              for (int d = 0; d < dlen; d++) begin
                byt = wd[8] ? m_data[8*d +: 8] : 8'h00;
                for (int b = 7; b >= 0; b--) begin m_bits.push_back(byt[b]); m_rd.push_back(!wd[8]); end
              end
              m_n = m_bits.size(); m_c = 0; m_busy = 1; m_held = 1;
              m_keep = wd[15]; m_wr = wd[8]; m_dlen = dlen; rx_i = 0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and device-side MISO
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      t = teff();
      e_sck = 1; e_mosi = 0; e_cs = !(m_held || m_busy);
      if (m_busy && m_c < m_n * t) begin
        s = m_c / t; k = m_c % t;
        e_sck  = !(k >= int'(m_tim[15:12]) && k < int'(m_tim[11:8]));
        e_mosi = m_bits[s];
        if (m_rd[s] && k == 0 && rx_i < rx_bits.size()) begin miso = rx_bits[rx_i]; rx_i++; end
      end
      chk("R11", "sck", 32'(sck), 32'(e_sck));
      chk("R2", "mosi", 32'(mosi), 32'(e_mosi));
      chk("R7", "cs_n", 32'(cs_n), 32'(e_cs));
    end
  end

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1; ra = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk); ra = a; #1;
    chk(req, "reg read", rd, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); ra = 3'd3; #1;
      if (!rd[22]) break;
    end
  endtask

  function automatic logic [31:0] mk(logic [7:0] opc, bit w, int dl, bit kp, int dm, int al);
    return {5'b0, 3'b000, 1'b0, 3'(al), 4'(dm), kp, 3'b000, 3'(dl), w, opc};
  endfunction

  task automatic set_rx(logic [31:0] bytes, int n);
    rx_bits.delete(); rx_word = '0;
    for (int i = 0; i < n; i++) begin
      rx_word[8*i +: 8] = bytes[8*i +: 8];
      for (int b = 7; b >= 0; b--) rx_bits.push_back(bytes[8*i + b]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R12", "cs_n after reset", 32'(cs_n), 32'd1);
    chk("R12", "sck after reset", 32'(sck), 32'd1);
    rd_chk("R12", 3'd3, 32'h0);
    rd_chk("R12", 3'd4, 32'h0000_0204);
    cmp_en = 1;

    // read: opcode, 3 address bytes, 1 dummy, 3 data bytes
    wr_reg(3'd0, 32'h0012_3456);
    set_rx(32'h0081_C35A, 3);
    wr_reg(3'd2, mk(8'h9F, 0, 3, 0, 1, 3));
    rd_chk("R1", 3'd3, stat_exp());
    chk("R1", "pending set", stat_exp(), 32'h0040_0000);
    wait_idle();
    rd_chk("R6", 3'd1, 32'h0081_C35A);
    rd_chk("R1", 3'd3, 32'h0);

    // write held over several commands, then release
    wr_reg(3'd1, 32'hA1B2_C3D4);
    wr_reg(3'd0, 32'h0000_ABCD);
    wr_reg(3'd2, mk(8'h02, 1, 4, 1, 0, 2));
    wait_idle();
    chk("R7", "held after keep", 32'(cs_n), 32'd0);
    wr_reg(3'd1, 32'h1122_3344);
    wr_reg(3'd2, mk(8'hFF, 1, 2, 1, 0, 0));
    wait_idle();
    chk("R5", "held after continuation", 32'(cs_n), 32'd0);
    wr_reg(3'd2, mk(8'h00, 0, 0, 0, 0, 0));
    wait_idle();
    @(negedge clk);
    chk("R7", "released", 32'(cs_n), 32'd1);

    // shifted timing: slot 5, fall 1, rise 3
    wr_reg(3'd4, 32'h0000_1305);
    set_rx(32'h0000_00E7, 1);
    wr_reg(3'd2, mk(8'h0B, 0, 1, 0, 0, 1));
    wait_idle();
    rd_chk("R11", 3'd1, 32'h0000_00E7);

    // slot length below 2 acts as 2; dummy-only tail
    wr_reg(3'd4, 32'h0000_0100);
    wr_reg(3'd2, mk(8'h06, 0, 0, 0, 2, 0));
    wait_idle();
    rd_chk("R4", 3'd3, 32'h0);
    wr_reg(3'd4, 32'h0000_0204);

    // command while pending
    set_rx(32'h0000_3C96, 2);
    wr_reg(3'd2, mk(8'h05, 0, 2, 0, 0, 0));
    wr_reg(3'd2, mk(8'hAA, 1, 4, 0, 0, 3));
    rd_chk("R8", 3'd3, 32'h2040_0000);
    wait_idle();
    rd_chk("R8", 3'd1, 32'h0000_3C96);
    wr_reg(3'd3, 32'h0000_0001);
    rd_chk("R10", 3'd3, 32'h2000_0000);
    wr_reg(3'd3, 32'h2000_0000);
    rd_chk("R10", 3'd3, 32'h0);

    // address while held is refused
    set_rx(32'h0000_0042, 1);
    wr_reg(3'd2, mk(8'h03, 0, 1, 1, 0, 3));
    wait_idle();
    wr_reg(3'd2, mk(8'h00, 0, 1, 1, 0, 1));
    rd_chk("R9", 3'd3, 32'h2000_0000);
    chk("R9", "still held", 32'(cs_n), 32'd0);
    wr_reg(3'd2, mk(8'h00, 0, 0, 0, 0, 0));
    wait_idle();
    wr_reg(3'd3, 32'h2000_0000);

    // oversize address length is refused
    wr_reg(3'd2, mk(8'h01, 0, 0, 0, 0, 4));
    rd_chk("R9", 3'd3, 32'h2000_0000);
    chk("R9", "no select", 32'(cs_n), 32'd1);
    wr_reg(3'd2, mk(8'h01, 0, 5, 0, 0, 0));
    rd_chk("R9", 3'd3, 32'h2000_0000);
    chk("R3", "model idle", 32'(m_busy), 32'd0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule